// File: doc/BRIEF.md
# SPI-Mode Card Select and Read-Token Handler

This block is the SPI-mode side of a memory-card host. It drives two active-low card selects and moves command and data bytes over a serial link, one bit per card-clock period. All transfers are framed in eight-clock byte slots. A slot boundary is counted from the moment a select goes low. A small configuration word holds the enables, the target card and a CRC option. Selects follow that word only on a falling edge of the card clock, so a register write never glitches the bus.

Software writes one byte at a time with `sendReq`. A request waits for the next byte boundary and then shifts out MSB first. A read request hunts the incoming byte stream for a start token and then hands the data bytes out one per `rxValid` pulse. With CRC enabled it also consumes the trailing check bytes. An error token ends the read at once. It latches the offending byte and raises a sticky error flag. Completion raises a separate sticky done flag. Both flags clear by writing a one to the matching clear strobe.

The design runs on a fast system clock. It detects card-clock edges by sampling the card-clock level. Data is driven on falling edges and sampled on rising edges.

Top module: `cardSpiLink`

## Requirements
- R1: After reset both selects are high (`csN` = 2'b11), `cardDout` is 1, `busy`, `statDone` and `statErr` are 0, and every configuration bit (CRC included) is 0.
- R2: `csN[0]` selects card 0 (`cardSel` = 0) and `csN[1]` selects card 1. The two bits are never low together, and retargeting releases the old select on the same falling edge that asserts the new one.
- R3: A configuration write changes `csN` only at the next falling edge of `cardClk`, never in the cycle of the write. Between falling edges the selects hold their value.
- R4: A select is asserted only while both the SPI enable and the select enable are 1. Clearing either one releases the select on the next falling edge.
- R5: A byte given with `sendReq` appears on `cardDout` MSB first, one bit per falling edge. It starts on an eight-clock boundary counted from the edge that asserted the select. `cardDout` idles at 1.
- R6: During a read, 0xFF and 0x00 bytes are skipped. After the start token 0xFE, the next DATA_BYTES bytes appear in order on `rxData` with one `rxValid` pulse each, and then `statDone` sets.
- R7: While hunting, a byte whose upper three bits are 000 and which is not 0x00 is an error token. It ends the read with no `rxValid`, sets `statErr`, holds the byte on `errToken` and clears `busy`.
- R8: With CRC enabled, CRC_BYTES bytes after the data are consumed without `rxValid`, and `statDone` sets only after them. With CRC disabled, `statDone` sets right after the last data byte.
- R9: `statDone` and `statErr` stay set until a one is written to `clrDone` or `clrErr` respectively.
- R10: `cfgData` bit fields: [0] SPI enable, [1] select enable, [2] card select, [3] CRC enable, loaded when `cfgWr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgData | input | 4 | Configuration word (see R10) |
| sendReq | input | 1 | Request to transmit `sendByte` |
| sendByte | input | 8 | Byte to transmit |
| readReq | input | 1 | Request to start a token-framed read |
| clrDone | input | 1 | Write-one-to-clear for `statDone` |
| clrErr | input | 1 | Write-one-to-clear for `statErr` |
| cardClk | input | 1 | Card clock level |
| cardDin | input | 1 | Serial data from card |
| cardDout | output | 1 | Serial data to card |
| csN | output | 2 | Active-low card selects |
| busy | output | 1 | Request pending or transfer running |
| rxValid | output | 1 | One-cycle strobe for a received data byte |
| rxData | output | 8 | Received data byte |
| statDone | output | 1 | Sticky read-complete flag |
| statErr | output | 1 | Sticky error-token flag |
| errToken | output | 8 | Last error token received |

## Verification
The bench writes the configuration just after a rising card-clock edge. A design that followed the write at once would move `csN` before the falling edge. It also retargets from card 0 to card 1, where a two-step update would leave both selects low or both high. A card model keeps its own slot count from the select edge, so a transmit started off-boundary shows up as a corrupted byte. Reads are fed 0x00 ahead of the start token, an error token followed by more bytes, and trailing CRC bytes. A design that took 0x00 as an error, kept reading after an error, or forwarded CRC bytes would put wrong items in the scoreboard or flip the sticky flags at the wrong time.

// File: rtl/cardSpiPkg.sv
package cardSpiPkg;

  typedef struct packed {
    logic loadTx;   // load a new byte into the transmit shifter
    logic rxEn;     // shift received bits and report byte completion
    logic count;    // advance the slot bit counter on rising edges
    logic bitClr;   // restart slot framing (select changed)
  } linkCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_HUNT,
    ST_DATA,
    ST_CRC
  } linkState_e;

endpackage

// File: rtl/cardSpiDatapath.sv
module cardSpiDatapath
  import cardSpiPkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cardClk,
  input  logic                 cardDin,
  input  logic [BYTE_BITS-1:0] txByte,
  input  linkCtl_t             ctl,
  output logic                 fall,
  output logic                 rise,
  output logic                 atBoundary,
  output logic                 byteDone,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 cardDout
);

  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic                 clkPrev;
  logic [CNT_W-1:0]     bitCnt;
  logic [BYTE_BITS-1:0] txSh;
  logic [BYTE_BITS-1:0] rxSh;

  assign fall       = clkPrev & ~cardClk;
  assign rise       = ~clkPrev & cardClk;
  assign atBoundary = (bitCnt == '0);
  assign byteDone   = rise & ctl.rxEn & (bitCnt == LAST_BIT);
  assign rxByte     = {rxSh[BYTE_BITS-2:0], cardDin};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      bitCnt  <= '0;
      txSh    <= '1;
      rxSh    <= '1;
      cardDout <= 1'b1;
    end else begin
      clkPrev <= cardClk;
      if (ctl.bitClr) begin
        bitCnt <= '0;
      end else if (rise && ctl.count) begin
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
      if (ctl.bitClr) begin
        txSh     <= '1;
        cardDout <= 1'b1;
      end else if (ctl.loadTx) begin
        cardDout <= txByte[BYTE_BITS-1];
        txSh     <= {txByte[BYTE_BITS-2:0], 1'b1};
      end else if (fall) begin
        cardDout <= txSh[BYTE_BITS-1];
        txSh     <= {txSh[BYTE_BITS-2:0], 1'b1};
      end
      if (rise && ctl.rxEn) begin
        rxSh <= {rxSh[BYTE_BITS-2:0], cardDin};
      end
    end
  end

  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (rise && ctl.count && !ctl.bitClr && bitCnt == LAST_BIT) |=> (bitCnt == '0)); // R5

endmodule

// File: rtl/cardSpiControl.sv
module cardSpiControl
  import cardSpiPkg::*;
#(
  parameter int BYTE_BITS   = 8,
  parameter int DATA_BYTES  = 4,
  parameter int CRC_BYTES   = 2,
  parameter logic [BYTE_BITS-1:0] START_TOKEN = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  logic [3:0]           cfgData,
  input  logic                 sendReq,
  input  logic [BYTE_BITS-1:0] sendByte,
  input  logic                 readReq,
  input  logic                 clrDone,
  input  logic                 clrErr,
  input  logic                 fall,
  input  logic                 rise,
  input  logic                 atBoundary,
  input  logic                 byteDone,
  input  logic [BYTE_BITS-1:0] rxByte,
  output linkCtl_t             ctl,
  output logic [BYTE_BITS-1:0] txByte,
  output logic [1:0]           csN,
  output logic                 busy,
  output logic                 rxValid,
  output logic [BYTE_BITS-1:0] rxData,
  output logic                 statDone,
  output logic                 statErr,
  output logic [BYTE_BITS-1:0] errToken
);

  localparam int TOTAL = DATA_BYTES + CRC_BYTES + 1;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_CRC  = IDX_W'(CRC_BYTES - 1);

  logic       cfgSpiEn, cfgCsEn, cfgSel, cfgCrc;
  logic [1:0] selNext;
  logic       selected, csChange, startOp, isErrTok;
  logic       sendPend, readPend;
  logic [IDX_W-1:0] byteIdx;
  linkState_e state;

  assign selNext  = (cfgSpiEn && cfgCsEn) ? (cfgSel ? 2'b01 : 2'b10) : 2'b11;
  assign selected = (csN != 2'b11);
  assign csChange = fall && (selNext != csN);
  assign startOp  = fall && atBoundary && selected && !csChange &&
                    (state == ST_IDLE) && (sendPend || readPend);
  assign isErrTok = (rxByte[BYTE_BITS-1:BYTE_BITS-3] == 3'b000) && (rxByte != '0);
  assign busy     = (state != ST_IDLE) || sendPend || readPend;

  always_comb begin
    ctl.loadTx = startOp && sendPend;
    ctl.rxEn   = (state != ST_IDLE);
    ctl.count  = selected;
    ctl.bitClr = csChange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {cfgCrc, cfgSel, cfgCsEn, cfgSpiEn} <= 4'b0000;
      csN      <= 2'b11;
      sendPend <= 1'b0;
      readPend <= 1'b0;
      txByte   <= '0;
      state    <= ST_IDLE;
      byteIdx  <= '0;
      rxValid  <= 1'b0;
      rxData   <= '0;
      statDone <= 1'b0;
      statErr  <= 1'b0;
      errToken <= '0;
    end else begin
      rxValid <= 1'b0;
      if (clrDone) statDone <= 1'b0;
      if (clrErr)  statErr  <= 1'b0;
      if (cfgWr) {cfgCrc, cfgSel, cfgCsEn, cfgSpiEn} <= cfgData;
      if (fall) csN <= selNext;
      if (sendReq && !busy) begin
        sendPend <= 1'b1;
        txByte   <= sendByte;
      end else if (readReq && !busy) begin
        readPend <= 1'b1;
      end
      if (csChange) begin
        state <= ST_IDLE;
      end else if (startOp) begin
        byteIdx <= '0;
        if (sendPend) begin
          state    <= ST_SEND;
          sendPend <= 1'b0;
        end else begin
          state    <= ST_HUNT;
          readPend <= 1'b0;
        end
      end else if (byteDone) begin
        case (state)
          ST_SEND: state <= ST_IDLE;
          ST_HUNT: begin
            if (rxByte == START_TOKEN) begin
              state <= ST_DATA;
            end else if (isErrTok) begin
              state    <= ST_IDLE;
              statErr  <= 1'b1;
              errToken <= rxByte;
            end
          end
          ST_DATA: begin
            rxValid <= 1'b1;
            rxData  <= rxByte;
            if (byteIdx == LAST_DATA) begin
              byteIdx <= '0;
              if (cfgCrc && CRC_BYTES > 0) begin
                state <= ST_CRC;
              end else begin
                state    <= ST_IDLE;
                statDone <= 1'b1;
              end
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
          ST_CRC: begin
            if (byteIdx == LAST_CRC) begin
              state    <= ST_IDLE;
              statDone <= 1'b1;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    csN != 2'b00); // R2
  AST_CS_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !fall |=> $stable(csN)); // R3
  AST_CS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (fall && !(cfgSpiEn && cfgCsEn)) |=> (csN == 2'b11)); // R4
  AST_ERR_ENDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statErr) |-> (state == ST_IDLE)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statDone && !clrDone) |=> statDone); // R9
  AST_NO_RX_IN_HUNT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT) |=> !rxValid); // R6

endmodule

// File: rtl/cardSpiLink.sv
module cardSpiLink
  import cardSpiPkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int DATA_BYTES = 4,
  parameter int CRC_BYTES  = 2,
  parameter logic [BYTE_BITS-1:0] START_TOKEN = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  logic [3:0]           cfgData,
  input  logic                 sendReq,
  input  logic [BYTE_BITS-1:0] sendByte,
  input  logic                 readReq,
  input  logic                 clrDone,
  input  logic                 clrErr,
  input  logic                 cardClk,
  input  logic                 cardDin,
  output logic                 cardDout,
  output logic [1:0]           csN,
  output logic                 busy,
  output logic                 rxValid,
  output logic [BYTE_BITS-1:0] rxData,
  output logic                 statDone,
  output logic                 statErr,
  output logic [BYTE_BITS-1:0] errToken
);

  linkCtl_t             ctl;
  logic                 fall, rise, atBoundary, byteDone;
  logic [BYTE_BITS-1:0] rxByte, txByte;

  cardSpiControl #(
    .BYTE_BITS(BYTE_BITS), .DATA_BYTES(DATA_BYTES),
    .CRC_BYTES(CRC_BYTES), .START_TOKEN(START_TOKEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .sendReq(sendReq), .sendByte(sendByte), .readReq(readReq),
    .clrDone(clrDone), .clrErr(clrErr), .fall(fall), .rise(rise),
    .atBoundary(atBoundary), .byteDone(byteDone), .rxByte(rxByte),
    .ctl(ctl), .txByte(txByte), .csN(csN), .busy(busy),
    .rxValid(rxValid), .rxData(rxData), .statDone(statDone),
    .statErr(statErr), .errToken(errToken)
  );

  cardSpiDatapath #(.BYTE_BITS(BYTE_BITS)) uPath (
    .clk(clk), .rstN(rstN), .cardClk(cardClk), .cardDin(cardDin),
    .txByte(txByte), .ctl(ctl), .fall(fall), .rise(rise),
    .atBoundary(atBoundary), .byteDone(byteDone), .rxByte(rxByte),
    .cardDout(cardDout)
  );

endmodule

// File: tb/cardSpiLink_test.sv
module cardSpiLink_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [3:0] cfgData = 4'h0;
  logic       sendReq = 1'b0;
  logic [7:0] sendByte = 8'h00;
  logic       readReq = 1'b0;
  logic       clrDone = 1'b0;
  logic       clrErr = 1'b0;
  logic       cardClk = 1'b0;
  logic       cardDin = 1'b1;
  logic       cardDout;
  logic [1:0] csN;
  logic       busy, rxValid, statDone, statErr;
  logic [7:0] rxData, errToken;

  int testsRun = 0;
  int testsFailed = 0;
  bit bothLow = 1'b0;

  logic [7:0] cardQ[$];
  logic [7:0] txExp[$];
  logic [7:0] rxExp[$];

  cardSpiLink uut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .sendReq(sendReq), .sendByte(sendByte), .readReq(readReq),
    .clrDone(clrDone), .clrErr(clrErr), .cardClk(cardClk),
    .cardDin(cardDin), .cardDout(cardDout), .csN(csN), .busy(busy),
    .rxValid(rxValid), .rxData(rxData), .statDone(statDone),
    .statErr(statErr), .errToken(errToken)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Card clock plus card-side model: drives on falls, samples on rises,
  // framing its own bytes from the select edge.
  initial begin
    logic [1:0] lastCs = 2'b11;
    logic [7:0] outSh = 8'hFF;
    logic [7:0] inSh = 8'hFF;
    int cnt = 0;
    forever begin
      @(negedge clk) cardClk = 1'b0;
      @(negedge clk);
      if (csN != lastCs) begin
        cnt = 0;
        lastCs = csN;
      end
      if (cnt == 0) outSh = (cardQ.size() > 0) ? cardQ.pop_front() : 8'hFF;
      cardDin = outSh[7];
      outSh = {outSh[6:0], 1'b1};
      cnt = (cnt + 1) % 8;
      @(negedge clk) cardClk = 1'b1;
      @(negedge clk);
      inSh = {inSh[6:0], cardDout};
      if (cnt == 0 && csN != 2'b11 && inSh != 8'hFF) begin
        if (txExp.size() == 0) check(1'b0, "R5 unexpected byte", inSh, 8'hFF);
        else begin
          logic [7:0] e;
          e = txExp.pop_front();
          check(inSh == e, "R5 transmitted byte", inSh, e);
        end
      end
    end
  end

  // Monitor: received bytes against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (csN == 2'b00) bothLow = 1'b1;
      if (rxValid) begin
        if (rxExp.size() == 0) check(1'b0, "R6/R8 unexpected rxValid", rxData, 0);
        else begin
          logic [7:0] e;
          e = rxExp.pop_front();
          check(rxData == e, "R6 received byte", rxData, e);
        end
      end
    end
  end

  task automatic writeCfg(input logic [3:0] v);
    @(negedge clk); cfgWr = 1'b1; cfgData = v;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic afterRise();
    @(posedge cardClk); @(posedge clk); @(negedge clk);
  endtask

  task automatic afterFall();
    @(negedge cardClk); @(posedge clk); @(negedge clk);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendOne(input logic [7:0] b);
    txExp.push_back(b);
    @(negedge clk); sendReq = 1'b1; sendByte = b;
    @(negedge clk); sendReq = 1'b0;
    waitIdle();
  endtask

  task automatic pulseRead();
    @(negedge clk); readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
  endtask

  task automatic cardCycles(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(csN == 2'b11, "R1 csN", csN, 2'b11);
    check(cardDout == 1'b1, "R1 dout", cardDout, 1);
    check({busy, statDone, statErr} == 3'b000, "R1 flags", {busy, statDone, statErr}, 0);

    // R3 / R10: select card 0 (spi+cs enable), no change before the fall
    afterRise();
    writeCfg(4'b0011);
    check(csN == 2'b11, "R3 no change at write", csN, 2'b11);
    afterFall();
    check(csN == 2'b10, "R2 card0 select", csN, 2'b10);
    cardCycles(2);
    check(csN == 2'b10, "R3 select held", csN, 2'b10);

    // R5 transmit on byte boundaries
    sendOne(8'hA5);
    sendOne(8'h3C);
    cardCycles(12);
    check(txExp.size() == 0, "R5 all bytes seen", txExp.size(), 0);

    // R6 read with 0x00 skipped before start token
    rxExp = '{8'h11, 8'h22, 8'h33, 8'h44};
    cardQ = '{8'hFF, 8'hFF, 8'h00, 8'hFE, 8'h11, 8'h22, 8'h33, 8'h44};
    pulseRead();
    waitIdle();
    check(statDone == 1'b1, "R6 done set", statDone, 1);
    check(rxExp.size() == 0, "R6 all data out", rxExp.size(), 0);
    check(statErr == 1'b0, "R6 0x00 not error", statErr, 0);
    cardCycles(10);
    check(statDone == 1'b1, "R9 done sticky", statDone, 1);
    @(negedge clk); clrDone = 1'b1;
    @(negedge clk); clrDone = 1'b0;
    check(statDone == 1'b0, "R9 done cleared", statDone, 0);

    // R7 error token aborts read
    cardQ = '{8'hFF, 8'hFF, 8'h0B, 8'h55, 8'h66};
    pulseRead();
    waitIdle();
    check(statErr == 1'b1, "R7 err set", statErr, 1);
    check(errToken == 8'h0B, "R7 err token", errToken, 8'h0B);
    check(statDone == 1'b0, "R7 no done", statDone, 0);
    cardCycles(24);
    check(statErr == 1'b1, "R9 err sticky", statErr, 1);
    @(negedge clk); clrErr = 1'b1;
    @(negedge clk); clrErr = 1'b0;
    check(statErr == 1'b0, "R9 err cleared", statErr, 0);

    // R8 CRC bytes consumed when enabled
    writeCfg(4'b1011);
    rxExp = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    cardQ = '{8'hFF, 8'hFF, 8'hFE, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hC1, 8'hC2};
    pulseRead();
    while (rxExp.size() != 0) @(negedge clk);
    @(negedge clk);
    check(statDone == 1'b0 && busy == 1'b1, "R8 done waits for crc", {statDone, busy}, 2'b01);
    waitIdle();
    check(statDone == 1'b1, "R8 done after crc", statDone, 1);
    @(negedge clk); clrDone = 1'b1;
    @(negedge clk); clrDone = 1'b0;

    // R2 retarget to card 1 in one falling edge
    afterRise();
    writeCfg(4'b0111);
    check(csN == 2'b10, "R3 retarget waits", csN, 2'b10);
    afterFall();
    check(csN == 2'b01, "R2 card1 select", csN, 2'b01);
    sendOne(8'h96);
    cardCycles(12);
    check(txExp.size() == 0, "R5 card1 byte seen", txExp.size(), 0);

    // R4 clearing select enable releases, spi enable alone does nothing
    afterRise();
    writeCfg(4'b0101);
    check(csN == 2'b01, "R4 held until fall", csN, 2'b01);
    afterFall();
    check(csN == 2'b11, "R4 released", csN, 2'b11);
    writeCfg(4'b0110);
    cardCycles(3);
    check(csN == 2'b11, "R4 spi enable off", csN, 2'b11);

    check(!bothLow, "R2 never both low", bothLow, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule